// File: doc/BRIEF.md
# Loopback Sample Client

This block is a traffic source and sink for exercising a multi-channel packet link. Each channel has its own generator and its own checker. The generator sends packets of fixed length. Every beat of a packet carries a 16-bit count-stamp in its upper half and a 16-bit payload in its lower half. The payload is cut from a stored transmit pattern string, at a position selected by the stamp. The checker takes beats coming back from the link and rebuilds the expected payload from a separate receive pattern string, using the stamp that arrives with the beat. It also tracks stamp continuity and watches two CRC error flags that the link supplies.

In a simple loopback the two pattern strings are set equal. When two clients sit at opposite ends of a link, each client's transmit string is set equal to the other client's receive string. For that reason both strings are independent parameters. A run begins with a synchronous start pulse. It ends with a single verdict: pass once every channel has sent and received the configured number of clean packets, or fail at the first error. After either verdict the block goes quiet until the next start.

Top module: `lbk_client`

## Requirements
- R1: After reset the block is idle: done, pass and fail are low, and every tx_valid and rx_ready is low. A start pulse clears all flags and counters and begins a run. From the cycle after start, rx_ready is high on every channel until done.
- R2: Each transmitted beat carries the stamp in bits [31:16]. Bits [7:0] hold byte k of the transmit pattern and bits [15:8] hold byte k+1, where k = (2·stamp) mod PAT_LEN and byte i of a pattern is bits [8i+7:8i]. On every channel the stamp starts at STAMP_INIT (0 by default) and rises by one per accepted beat, modulo 2^16.
- R3: A packet is PKT_LEN beats long. tx_sop marks its first beat and tx_eop its last. While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value.
- R4: On each accepted receive beat (rx_valid and rx_ready both high), bits [15:0] are compared with the receive pattern bytes selected by that beat's own stamp, in the R2 layout. A mismatch, including on the first beat, sets fail.
- R5: The first accepted receive beat on a channel after start only loads the stamp tracker. Every later beat on that channel must carry the previous stamp plus one, modulo 2^16. Otherwise fail is set.
- R6: An accepted receive beat with rx_eop high and either rx_crc24_err or rx_crc32_err high sets fail.
- R7: fail is sticky until the next start. fail_ch holds the index of the failing channel. If several channels fail in the same cycle, the lowest index is recorded.
- R8: pass rises once NUM_PKTS packets have been sent and NUM_PKTS packets received on every channel with no failure. An error on the very last beat yields fail, not pass. pass and fail are never high together.
- R9: done is high exactly when pass or fail is high. While done is high, all tx_valid and rx_ready outputs are low.
- R10: Channels are independent. Each channel has its own stamp sequence, packet count and continuity tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Synchronous run start; clears flags and counters |
| tx_valid | output | NUM_CH | Per-channel transmit beat valid |
| tx_ready | input | NUM_CH | Per-channel transmit beat accepted |
| tx_data | output | NUM_CH*32 | Per-channel beat {stamp, payload}, channel c at bits [32c+31:32c] |
| tx_sop | output | NUM_CH | First beat of packet |
| tx_eop | output | NUM_CH | Last beat of packet |
| rx_valid | input | NUM_CH | Per-channel receive beat valid |
| rx_ready | output | NUM_CH | Per-channel receive ready (high while running) |
| rx_data | input | NUM_CH*32 | Per-channel received beat, same layout as tx_data |
| rx_eop | input | NUM_CH | Last beat of received packet |
| rx_crc24_err | input | NUM_CH | Link reports a CRC-24 error, qualified by rx_eop |
| rx_crc32_err | input | NUM_CH | Link reports a CRC-32 error, qualified by rx_eop |
| done | output | 1 | Run finished with a verdict |
| pass | output | 1 | All channels completed cleanly |
| fail | output | 1 | An error was detected |
| fail_ch | output | max(1,clog2(NUM_CH)) | Channel that caused the failure |

## Verification
The hardest cases to reach through the ports are two channels failing in the same clock, and a stamp sequence that crosses the 16-bit wrap. In loopback traffic neither happens: errors arrive one at a time, and the stamps stay far below 65535. To reach both cases, the bench disconnects its loopback model and drives the receive side directly. It opens channel 0 at stamp 0xFFFE and walks it across zero, which also covers a first stamp that is not zero. It then sends one discontinuous beat on both channels in the same cycle and expects channel 0 to be recorded. The loopback runs cover the other error kinds. In those runs a partner model re-encodes payloads with the receive string and corrupts, drops or CRC-flags exactly one chosen beat, including the final beat of the run.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  localparam int STAMP_W = 16;
  localparam int PAY_W   = 16;
  localparam int WORD_W  = STAMP_W + PAY_W;

  typedef logic [STAMP_W-1:0] stamp_t;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_DONE = 2'd2
  } run_state_t;

  // successor of a stamp, wrapping modulo 2^STAMP_W
  function automatic stamp_t stamp_succ(input stamp_t s);
    return s + stamp_t'(1);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input stamp_t s,
                                                  input logic [PAY_W-1:0] p);
    return {s, p};
  endfunction

endpackage

// File: rtl/lbk_word_gen.sv
module lbk_word_gen
  import lbk_pkg::*;
#(
  parameter int                   PAT_LEN = 8,
  parameter logic [PAT_LEN*8-1:0] PAT     = '0
) (
  input  stamp_t             stamp,
  output logic [PAY_W-1:0]   payload
);

  localparam int PAT_W = PAT_LEN * 8;

  // two consecutive pattern bytes starting at (2*stamp) mod PAT_LEN
  function automatic logic [PAY_W-1:0] pat_pair(input stamp_t s);
    logic [31:0]      k;
    logic [PAT_W-1:0] sh;
    k  = ({16'd0, s} * 32'd2) % 32'(PAT_LEN);
    sh = PAT >> (k * 32'd8);
    return sh[PAY_W-1:0];
  endfunction

  assign payload = pat_pair(stamp);

endmodule

// File: rtl/lbk_tx_gen.sv
module lbk_tx_gen
  import lbk_pkg::*;
#(
  parameter int                   PKT_LEN    = 4,
  parameter int                   NUM_PKTS   = 100,
  parameter int                   PAT_LEN    = 8,
  parameter logic [PAT_LEN*8-1:0] PAT        = '0,
  parameter logic [15:0]          STAMP_INIT = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              sop,
  output logic              eop,
  output logic              all_sent
);

  localparam int CNT_W  = $clog2(NUM_PKTS + 1);
  localparam int BEAT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PKT_LEN - 1);
  localparam logic [CNT_W-1:0]  PKT_GOAL  = CNT_W'(NUM_PKTS);

  stamp_t            stamp_q;
  logic [BEAT_W-1:0] beat_q;
  logic [CNT_W-1:0]  sent_q;
  logic [PAY_W-1:0]  pay;
  logic              beat_taken;

  assign all_sent   = (sent_q == PKT_GOAL);
  assign valid      = run && !all_sent;
  assign beat_taken = valid && ready;
  assign sop        = (beat_q == '0);
  assign eop        = (beat_q == LAST_BEAT);

  lbk_word_gen #(
    .PAT_LEN (PAT_LEN),
    .PAT     (PAT)
  ) u_word (
    .stamp   (stamp_q),
    .payload (pay)
  );

  assign data = pack_word(stamp_q, pay);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      stamp_q <= STAMP_INIT;
      beat_q  <= '0;
      sent_q  <= '0;
    end else if (beat_taken) begin
      stamp_q <= stamp_succ(stamp_q);
      if (eop) begin
        beat_q <= '0;
        sent_q <= sent_q + CNT_W'(1);
      end else begin
        beat_q <= beat_q + BEAT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lbk_rx_chk.sv
module lbk_rx_chk
  import lbk_pkg::*;
#(
  parameter int                   NUM_PKTS = 100,
  parameter int                   PAT_LEN  = 8,
  parameter logic [PAT_LEN*8-1:0] PAT      = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic [WORD_W-1:0] data,
  input  logic              eop,
  input  logic              crc24_err,
  input  logic              crc32_err,
  output logic              err_payload,
  output logic              err_seq,
  output logic              err_crc,
  output logic              all_got
);

  localparam int CNT_W = $clog2(NUM_PKTS + 1);
  localparam logic [CNT_W-1:0] PKT_GOAL = CNT_W'(NUM_PKTS);

  stamp_t           rx_stamp;
  logic [PAY_W-1:0] rx_pay;
  logic [PAY_W-1:0] exp_pay;
  logic             have_q;
  stamp_t           last_q;
  logic [CNT_W-1:0] got_q;

  assign rx_stamp = data[WORD_W-1:PAY_W];
  assign rx_pay   = data[PAY_W-1:0];

  lbk_word_gen #(
    .PAT_LEN (PAT_LEN),
    .PAT     (PAT)
  ) u_word (
    .stamp   (rx_stamp),
    .payload (exp_pay)
  );

  assign err_payload = accept && (rx_pay != exp_pay);
  assign err_seq     = accept && have_q && (rx_stamp != stamp_succ(last_q));
  assign err_crc     = accept && eop && (crc24_err || crc32_err);
  assign all_got     = (got_q == PKT_GOAL);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_q <= 1'b0;
      last_q <= '0;
      got_q  <= '0;
    end else if (accept) begin
      have_q <= 1'b1;
      last_q <= rx_stamp;
      if (eop && !all_got) got_q <= got_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/lbk_client.sv
module lbk_client
  import lbk_pkg::*;
#(
  parameter int              NUM_CH     = 2,
  parameter int              PKT_LEN    = 4,
  parameter int              NUM_PKTS   = 100,
  parameter int              PAT_LEN    = 8,
  parameter logic [PAT_LEN*8-1:0] TX_PAT = "LOOPBACK",
  parameter logic [PAT_LEN*8-1:0] RX_PAT = "LOOPBACK",
  parameter logic [15:0]     STAMP_INIT = 16'h0000,
  localparam int             CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic [NUM_CH-1:0]        tx_valid,
  input  logic [NUM_CH-1:0]        tx_ready,
  output logic [NUM_CH*WORD_W-1:0] tx_data,
  output logic [NUM_CH-1:0]        tx_sop,
  output logic [NUM_CH-1:0]        tx_eop,
  input  logic [NUM_CH-1:0]        rx_valid,
  output logic [NUM_CH-1:0]        rx_ready,
  input  logic [NUM_CH*WORD_W-1:0] rx_data,
  input  logic [NUM_CH-1:0]        rx_eop,
  input  logic [NUM_CH-1:0]        rx_crc24_err,
  input  logic [NUM_CH-1:0]        rx_crc32_err,
  output logic                     done,
  output logic                     pass,
  output logic                     fail,
  output logic [CH_W-1:0]          fail_ch
);

  run_state_t        state_q;
  logic              pass_q;
  logic              fail_q;
  logic [CH_W-1:0]   fail_ch_q;

  logic              run;
  logic [NUM_CH-1:0] rx_take;
  logic [NUM_CH-1:0] ch_err;
  logic [NUM_CH-1:0] ch_sent;
  logic [NUM_CH-1:0] ch_got;
  logic              err_any;
  logic [CH_W-1:0]   err_first;
  logic              all_complete;

  assign run      = (state_q == RS_RUN);
  assign rx_ready = {NUM_CH{run}};
  assign rx_take  = rx_valid & rx_ready;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic e_pay, e_seq, e_crc;

    lbk_tx_gen #(
      .PKT_LEN    (PKT_LEN),
      .NUM_PKTS   (NUM_PKTS),
      .PAT_LEN    (PAT_LEN),
      .PAT        (TX_PAT),
      .STAMP_INIT (STAMP_INIT)
    ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .run      (run),
      .ready    (tx_ready[g]),
      .valid    (tx_valid[g]),
      .data     (tx_data[g*WORD_W +: WORD_W]),
      .sop      (tx_sop[g]),
      .eop      (tx_eop[g]),
      .all_sent (ch_sent[g])
    );

    lbk_rx_chk #(
      .NUM_PKTS (NUM_PKTS),
      .PAT_LEN  (PAT_LEN),
      .PAT      (RX_PAT)
    ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start),
      .accept      (rx_take[g]),
      .data        (rx_data[g*WORD_W +: WORD_W]),
      .eop         (rx_eop[g]),
      .crc24_err   (rx_crc24_err[g]),
      .crc32_err   (rx_crc32_err[g]),
      .err_payload (e_pay),
      .err_seq     (e_seq),
      .err_crc     (e_crc),
      .all_got     (ch_got[g])
    );

    assign ch_err[g] = e_pay || e_seq || e_crc;
  end

  // lowest-index failing channel wins
  always_comb begin
    err_any   = 1'b0;
    err_first = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (ch_err[c]) begin
        err_any   = 1'b1;
        err_first = CH_W'(c);
      end
    end
  end

  assign all_complete = (&ch_sent) && (&ch_got);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= RS_IDLE;
      pass_q    <= 1'b0;
      fail_q    <= 1'b0;
      fail_ch_q <= '0;
    end else if (start) begin
      state_q   <= RS_RUN;
      pass_q    <= 1'b0;
      fail_q    <= 1'b0;
      fail_ch_q <= '0;
    end else if (run) begin
      if (err_any) begin
        fail_q    <= 1'b1;
        fail_ch_q <= err_first;
        state_q   <= RS_DONE;
      end else if (all_complete) begin
        pass_q  <= 1'b1;
        state_q <= RS_DONE;
      end
    end
  end

  assign done    = (state_q == RS_DONE);
  assign pass    = pass_q;
  assign fail    = fail_q;
  assign fail_ch = fail_ch_q;

endmodule

// File: rtl/lbk_client_chk.sv
module lbk_client_chk #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int WORD_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [NUM_CH-1:0]        tx_valid,
  input logic [NUM_CH-1:0]        tx_ready,
  input logic [NUM_CH*WORD_W-1:0] tx_data,
  input logic [NUM_CH-1:0]        rx_valid,
  input logic [NUM_CH-1:0]        rx_ready,
  input logic [NUM_CH-1:0]        rx_eop,
  input logic [NUM_CH-1:0]        rx_crc24_err,
  input logic [NUM_CH-1:0]        rx_crc32_err,
  input logic                     done,
  input logic                     pass,
  input logic                     fail,
  input logic [CH_W-1:0]          fail_ch,
  input logic                     err_any
);

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !pass && !fail && (rx_ready == '1)));

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_ch)));

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  // R9
  done_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done == (pass || fail));

  // R9
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((tx_valid == '0) && (rx_ready == '0)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_chk
    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[g] && !tx_ready[g] && !start && !err_any) |=>
        (tx_valid[g] && $stable(tx_data[g*WORD_W +: WORD_W])));

    // R6
    crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[g] && rx_ready[g] && rx_eop[g] &&
       (rx_crc24_err[g] || rx_crc32_err[g]) && !start) |=> fail);
  end

endmodule

bind lbk_client lbk_client_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .WORD_W (lbk_pkg::WORD_W)
) u_client_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .rx_eop       (rx_eop),
  .rx_crc24_err (rx_crc24_err),
  .rx_crc32_err (rx_crc32_err),
  .done         (done),
  .pass         (pass),
  .fail         (fail),
  .fail_ch      (fail_ch),
  .err_any      (err_any)
);

// File: tb/lbk_client_bench.sv
module lbk_client_bench;

  localparam int NC = 2, PL = 4, NP = 100, NB = NP * PL;
  localparam logic [63:0] TXP = "ABCDEFGH";
  localparam logic [63:0] RXP = "qrstuvwx";

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NC-1:0] tx_valid, tx_ready, tx_sop, tx_eop;
  logic [NC-1:0] rx_valid, rx_ready, rx_eop, rx_c24, rx_c32;
  logic [NC*32-1:0] tx_data, rx_data;
  logic done, pass, fail;
  logic [0:0] fail_ch;

  always #5 clk = ~clk;

  lbk_client #(
    .NUM_CH (NC), .PKT_LEN (PL), .NUM_PKTS (NP), .PAT_LEN (8),
    .TX_PAT (TXP), .RX_PAT (RXP), .STAMP_INIT (16'h0000)
  ) u_lbk_client (
    .clk (clk), .rst_n (rst_n), .start (start),
    .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_data (tx_data),
    .tx_sop (tx_sop), .tx_eop (tx_eop),
    .rx_valid (rx_valid), .rx_ready (rx_ready), .rx_data (rx_data),
    .rx_eop (rx_eop), .rx_crc24_err (rx_c24), .rx_crc32_err (rx_c32),
    .done (done), .pass (pass), .fail (fail), .fail_ch (fail_ch)
  );

  int total = 0, bad = 0, cyc = 0, lcyc = 0;

  task automatic check(input string req, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // payload bytes picked by stamp: pair index is the stamp mod 4 for an 8-byte string
  function automatic logic [15:0] bw(input logic [63:0] pat, input logic [15:0] s);
    int k;
    k = 16 * int'(s[1:0]);
    return {pat[k+8 +: 8], pat[k +: 8]};
  endfunction

  // scoreboard: expected transmit beats per channel
  logic [31:0] edat [NC][0:511];
  logic [1:0]  efr  [NC][0:511];
  int          erd  [NC];
  // loopback link buffer per channel
  logic [15:0] lst  [NC][0:1023];
  logic        leop [NC][0:1023];
  int          lwr  [NC], lrd [NC], eops [NC];
  logic        stall_prev [NC];
  logic [31:0] stall_dat  [NC];
  int          inj_kind, inj_ch, inj_idx;

  task automatic push_expected();
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < NB; i++) begin
        logic [15:0] s;
        s = 16'(i);
        edat[c][i] = {s, bw(TXP, s)};
        efr[c][i]  = {(i % PL) == 0, (i % PL) == PL - 1};
      end
      erd[c] = 0; lwr[c] = 0; lrd[c] = 0; eops[c] = 0;
      stall_prev[c] = 1'b0;
    end
  endtask

  task automatic link_step();
    int i;
    logic [15:0] s;
    logic hit;
    lcyc++;
    for (int c = 0; c < NC; c++) begin
      if (stall_prev[c] && !done)
        check("R3 stall hold", tx_valid[c] && tx_data[c*32 +: 32] == stall_dat[c],
              {31'd0, tx_valid[c], tx_data[c*32 +: 32]}, {31'd0, 1'b1, stall_dat[c]});
      tx_ready[c] = ((lcyc * 3 + c * 5) % 7) != 0;
      rx_valid[c] = 1'b0; rx_eop[c] = 1'b0; rx_c24[c] = 1'b0; rx_c32[c] = 1'b0;
      if (rx_ready[c] && lrd[c] < lwr[c]) begin
        i = lrd[c]; s = lst[c][i]; lrd[c]++;
        hit = (c == inj_ch) && (i == inj_idx);
        if (!(hit && inj_kind == 2)) begin
          rx_valid[c] = 1'b1;
          rx_data[c*32 +: 32] = {s, bw(RXP, s) ^ ((hit && inj_kind == 1) ? 16'h0001 : 16'h0000)};
          rx_eop[c] = leop[c][i];
          rx_c24[c] = hit && inj_kind == 3;
          rx_c32[c] = hit && inj_kind == 4;
        end
      end
      stall_prev[c] = tx_valid[c] && !tx_ready[c];
      stall_dat[c]  = tx_data[c*32 +: 32];
      if (tx_valid[c] && tx_ready[c] && erd[c] < NB) begin
        i = erd[c];
        check("R2 tx beat", tx_data[c*32 +: 32] == edat[c][i],
              {32'd0, tx_data[c*32 +: 32]}, {32'd0, edat[c][i]});
        check("R3 sop/eop", {tx_sop[c], tx_eop[c]} == efr[c][i],
              {62'd0, tx_sop[c], tx_eop[c]}, {62'd0, efr[c][i]});
        erd[c]++;
        lst[c][lwr[c]]  = tx_data[c*32 + 16 +: 16];
        leop[c][lwr[c]] = tx_eop[c];
        lwr[c]++;
        if (tx_eop[c]) eops[c]++;
      end
    end
  endtask

  task automatic run_link(input int kind, input int ch, input int idx,
                          input logic exp_pass, input logic exp_ch, input string req);
    int n;
    push_expected();
    inj_kind = kind; inj_ch = ch; inj_idx = idx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      link_step();
      @(negedge clk);
      n++;
    end
    check({req, " done"}, done, {63'd0, done}, 64'd1);
    check(req, pass == exp_pass && fail == !exp_pass,
          {62'd0, pass, fail}, {62'd0, exp_pass, !exp_pass});
    if (!exp_pass)
      check({req, " R7 fail_ch"}, fail_ch == exp_ch, {63'd0, fail_ch}, {63'd0, exp_ch});
    check("R9 quiet at done", tx_valid == '0 && rx_ready == '0,
          {60'd0, tx_valid, rx_ready}, 64'd0);
    if (exp_pass) begin
      for (int c = 0; c < NC; c++) begin
        // R8 / R10: each channel completes its own packet count and stamp run
        check("R8 R10 packets per channel", eops[c] == NP && erd[c] == NB,
              64'(eops[c]), 64'(NP));
      end
    end
    tx_ready = '0; rx_valid = '0; rx_eop = '0; rx_c24 = '0; rx_c32 = '0;
    repeat (3) @(negedge clk);
    check("R9 stays quiet", tx_valid == '0 && rx_ready == '0 && done && pass == exp_pass,
          {58'd0, tx_valid, rx_ready, done, pass}, {62'd0, 1'b1, exp_pass});
  endtask

  function automatic logic [15:0] dp(input logic [15:0] s, input int mode);
    if (mode == 1) return bw(RXP, s) ^ 16'h0100;
    if (mode == 2) return bw(TXP, s);
    return bw(RXP, s);
  endfunction

  task automatic d_start();
    tx_ready = '0; rx_valid = '0; rx_eop = '0; rx_c24 = '0; rx_c32 = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic d_beat(input logic v0, input logic [15:0] s0,
                        input logic v1, input logic [15:0] s1, input int mode);
    rx_valid = {v1, v0};
    rx_data  = {s1, dp(s1, mode), s0, dp(s0, mode)};
    rx_eop   = '1;
    @(negedge clk);
    rx_valid = '0;
  endtask

  initial begin
    tx_ready = '0; rx_valid = '0; rx_data = '0; rx_eop = '0; rx_c24 = '0; rx_c32 = '0;
    inj_kind = 0; inj_ch = 0; inj_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset idle", !done && !pass && !fail && tx_valid == '0 && rx_ready == '0,
          {59'd0, done, pass, fail, tx_valid | rx_ready}, 64'd0);

    // direct drive: wrap and arbitrary first stamp
    d_start();
    check("R1 start opens rx", rx_ready == '1 && !done, {62'd0, rx_ready}, 64'd3);
    d_beat(1'b1, 16'hFFFE, 1'b1, 16'h1234, 0);
    d_beat(1'b1, 16'hFFFF, 1'b1, 16'h1235, 0);
    d_beat(1'b1, 16'h0000, 1'b0, 16'h0000, 0);
    d_beat(1'b1, 16'h0001, 1'b0, 16'h0000, 0);
    check("R5 wrap and first stamp accepted", !fail && !done, {62'd0, fail, done}, 64'd0);
    d_beat(1'b0, 16'h0000, 1'b1, 16'h1237, 0);
    check("R5 stamp gap fails", fail && done && fail_ch == 1'b1,
          {61'd0, fail, done, fail_ch}, 64'd7);

    // restart clears, then simultaneous errors
    d_start();
    check("R1 restart clears", !fail && !pass && !done, {61'd0, fail, pass, done}, 64'd0);
    d_beat(1'b1, 16'd3, 1'b1, 16'd7, 0);
    d_beat(1'b1, 16'd5, 1'b1, 16'd9, 0);
    check("R7 lowest channel wins", fail && fail_ch == 1'b0, {62'd0, fail, fail_ch}, 64'd2);

    // payload against receive string
    d_start();
    d_beat(1'b0, 16'd0, 1'b1, 16'd2, 1);
    check("R4 first-beat payload error", fail && fail_ch == 1'b1,
          {62'd0, fail, fail_ch}, 64'd3);
    d_start();
    d_beat(1'b1, 16'd0, 1'b0, 16'd0, 2);
    check("R4 tx string is not rx string", fail && fail_ch == 1'b0,
          {62'd0, fail, fail_ch}, 64'd2);

    // loopback runs through the partner model
    run_link(0, 0, 0,   1'b1, 1'b0, "R8 clean run pass");
    run_link(1, 1, 37,  1'b0, 1'b1, "R4 payload corruption");
    run_link(2, 0, 50,  1'b0, 1'b0, "R5 dropped beat");
    run_link(3, 1, 23,  1'b0, 1'b1, "R6 crc24 flag");
    run_link(4, 0, 399, 1'b0, 1'b0, "R6 R8 crc32 on final beat");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule